// File: doc/BRIEF.md
# Bit-Serial Bus EEPROM Protocol Engine

This block is the device side of a small nonvolatile memory that a host reaches through a single data-bus line. The host uses ordinary chip-enable, output-enable and write-enable strobes. Each host bus cycle moves exactly one bit. Commands are not framed by opcodes, a serial clock or a select pulse. The engine recognises them only from the order of single-bit read and write cycles. From that order it decodes a reset, an address load, a sequential read, a page load and the command that starts programming.

The strobes arrive asynchronously. They pass through two-flop synchronizers on the system clock, and a bus cycle counts as finished when its enable combination drops. The engine has three pieces of state besides its sequencer: a write-permission latch, a byte address counter and a 32-byte page buffer. During a read cycle it drives one bit back, which is either array data or a busy/ready flag. The storage is a behavioural 2K x 8 synchronous RAM that reads all-ones in every byte never programmed since reset. A programmable cycle count stands in for the nonvolatile programming time.

A host always opens an operation with a reset sequence, then shifts in 16 address bits. After that it either reads bytes or loads bytes and issues the start command. It then polls the line until the line reads 1.

Top module: `sbm_engine`

## Requirements
- R1: A write cycle is chip-enable low, write-enable low and output-enable high. Its data bit is the bus_din value held while the cycle was active, and the bit is taken when the cycle ends, meaning chip-enable or write-enable rises.
- R2: A read cycle is chip-enable low, output-enable low and write-enable high. bus_drive is 1 only during a read cycle, with the two-clock synchronizer delay. When bus_drive is 0, bus_dout is 0.
- R3: The ordered events read, write 0, read form a reset in any state. A reset aborts any read or load in progress. It sets the write-permission latch only if write-protect is high and no programming is running. Reads after a reset return 1 until 16 address bits are written, and a reset issued during programming does not stop the programming.
- R4: After a reset, 16 consecutive write cycles load the address, most significant bit first. Only the low 11 bits select a byte, and the upper 5 are sent as zero.
- R5: After the address, each group of 8 read cycles returns one byte, most significant bit first. The address then increments, and from 0x7FF it rolls over to 0x000.
- R6: A write cycle after a whole number of read bytes ends the read, and later reads return 1. A write cycle in the middle of a byte also ends the read and clears the write-permission latch.
- R7: Write cycles after the address fill a 32-byte page, 8 bits per byte, most significant bit first. The page is aligned to 32 bytes. The in-page pointer starts at address bits 4..0 and wraps from 31 to 0, so a later byte overwrites an earlier one. Programming changes only the bytes that were loaded.
- R8: After at least one whole byte is loaded, the events read, write 1, read start programming. They do so only if the write-permission latch is set, write-protect is high and no programming is running.
- R9: While programming runs, every read cycle returns 0. Outside the data-reading states a read returns 1 when the engine is not programming.
- R10: The write-permission latch is clear after reset and is cleared when programming completes. It is held clear while wp_n is low. Dropping wp_n during programming does not abort it, and a start attempt with wp_n low does nothing.
- R11: The engine goes to idle and clears the write-permission latch, with nothing programmed, in three cases: a read during address loading, a read after a partial byte of page data, and a second write after the read/write-1 that follows a page load.
- R12: Programming lasts PROG_CYCLES clock cycles from the start command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce_n | input | 1 | Chip-enable strobe, active low, asynchronous |
| bus_oe_n | input | 1 | Output-enable strobe, active low, asynchronous |
| bus_we_n | input | 1 | Write-enable strobe, active low, asynchronous |
| bus_din | input | 1 | Data bit from the host on the shared line |
| wp_n | input | 1 | Write-protect, low blocks programming |
| bus_dout | output | 1 | Bit returned to the host during a read cycle |
| bus_drive | output | 1 | High while the engine should drive the line |

## Verification
The assertions assume that the strobes stay at each level for at least three clocks, so every level survives the synchronizers. They also assume that bus_din is steady while a write cycle is active and that write-enable and output-enable are never low together under chip-enable. The bench changes inputs only on falling clock edges and holds each phase of a bus cycle for six clocks. It raises chip-enable together with the other strobe, and it never overlaps a read with a write. Under these conditions each host cycle produces exactly one decoded event, and the port-level timing that the drive and write-protect properties check stays fixed.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    // decoded end-of-cycle event from the bus
    typedef enum logic [1:0] {
        EV_NONE,
        EV_RD,
        EV_W0,
        EV_W1
    } bus_ev_e;

    // protocol sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POSTRST,
        ST_ADDR,
        ST_ADONE,
        ST_RDATA,
        ST_LOAD,
        ST_LCLOSE,
        ST_LARM
    } eng_st_e;

    // raw or synchronized strobe bundle
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic din;
        logic wp_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                        din: 1'b0, wp_n: 1'b0};

    localparam int BUS_ADDR_BITS = 16;

    function automatic bus_ev_e wr_event(input logic bit_v);
        return bit_v ? EV_W1 : EV_W0;
    endfunction

endpackage

// File: rtl/sbm_sync.sv
module sbm_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/sbm_bus_decode.sv
module sbm_bus_decode
    import sbm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  strobe_t strb,
    output bus_ev_e ev,
    output logic    rd_active
);
    logic wr_act, rd_act;
    logic wr_q, rd_q, din_q;

    assign wr_act    = !strb.ce_n && !strb.we_n && strb.oe_n;
    assign rd_act    = !strb.ce_n && !strb.oe_n && strb.we_n;
    assign rd_active = rd_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= 1'b0;
            rd_q  <= 1'b0;
            din_q <= 1'b0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
            if (wr_act) din_q <= strb.din;
        end
    end

    // a cycle ends when its enable combination falls away
    always_comb begin
        ev = EV_NONE;
        if (wr_q && !wr_act)      ev = wr_event(din_q);
        else if (rd_q && !rd_act) ev = EV_RD;
    end
endmodule

// File: rtl/sbm_array.sv
module sbm_array #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] written;

    // erased bytes read as all ones
    always_ff @(posedge clk) begin
        if (rst) written <= '0;
        else if (we) written[waddr] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= written[raddr] ? mem[raddr] : '1;
    end
endmodule

// File: rtl/sbm_ctrl.sv
module sbm_ctrl
    import sbm_pkg::*;
#(
    parameter int AW          = 11,
    parameter int PAGE_BYTES  = 32,
    parameter int PROG_CYCLES = 1000
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_e       ev,
    input  logic          wp_ok,
    input  logic [7:0]    rd_byte,
    output logic [AW-1:0] rd_addr,
    output logic          arr_we,
    output logic [AW-1:0] arr_waddr,
    output logic [7:0]    arr_wdata,
    output logic          out_bit,
    output logic          busy,
    output logic          wel
);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int GW = AW - PW;
    localparam int CW = $clog2(PROG_CYCLES + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(PROG_CYCLES - 1);
    localparam logic [CW-1:0] PAGE_CNT = CW'(PAGE_BYTES);
    localparam logic [3:0]    ABIT_LAST = 4'(BUS_ADDR_BITS - 1);

    eng_st_e         st;
    bus_ev_e         hist1, hist2;
    logic [2:0]      bitcnt;
    logic [3:0]      abits;
    logic [AW-1:0]   addr;
    logic [7:0]      shreg;
    logic [PW-1:0]   pptr;
    logic [GW-1:0]   lpage, ppage;
    logic [PAGE_BYTES-1:0] pvalid;
    logic [CW-1:0]   pcnt;
    logic [7:0]      pbuf [PAGE_BYTES];

    logic            is_wr, wbit, rst_seq, start_nv, pbuf_we, data_bit;
    logic [AW-1:0]   addr_shift;
    logic [7:0]      sh_next;
    logic [PW-1:0]   pidx;

    assign is_wr      = (ev == EV_W0) || (ev == EV_W1);
    assign wbit       = (ev == EV_W1);
    assign rst_seq    = (ev == EV_RD) && (hist1 == EV_W0) && (hist2 == EV_RD);
    assign addr_shift = {addr[AW-2:0], wbit};
    assign sh_next    = {shreg[6:0], wbit};
    assign start_nv   = !rst_seq && (st == ST_LARM) && (ev == EV_RD) && wel && wp_ok && !busy;
    assign pbuf_we    = is_wr && (st == ST_LOAD) && (bitcnt == 3'd7) && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            hist1  <= EV_NONE;
            hist2  <= EV_NONE;
            bitcnt <= '0;
            abits  <= '0;
            addr   <= '0;
            shreg  <= '0;
            pptr   <= '0;
            lpage  <= '0;
            ppage  <= '0;
            pvalid <= '0;
            pcnt   <= '0;
            busy   <= 1'b0;
            wel    <= 1'b0;
        end else begin
            if (ev != EV_NONE) begin
                hist2 <= hist1;
                hist1 <= ev;
            end
            if (rst_seq) begin
                st     <= ST_POSTRST;
                bitcnt <= '0;
                abits  <= '0;
                if (wp_ok && !busy) wel <= 1'b1;
            end else if (ev != EV_NONE) begin
                case (st)
                    ST_IDLE: if (is_wr) wel <= 1'b0;
                    ST_POSTRST: if (is_wr) begin
                        addr  <= addr_shift;
                        abits <= 4'd1;
                        st    <= ST_ADDR;
                    end
                    ST_ADDR: if (is_wr) begin
                        addr  <= addr_shift;
                        abits <= abits + 4'd1;
                        if (abits == ABIT_LAST) begin
                            st     <= ST_ADONE;
                            bitcnt <= '0;
                            pptr   <= addr_shift[PW-1:0];
                            lpage  <= addr_shift[AW-1:PW];
                            if (!busy) pvalid <= '0;
                        end
                    end else begin
                        st  <= ST_IDLE;
                        wel <= 1'b0;
                    end
                    ST_ADONE: begin
                        bitcnt <= 3'd1;
                        if (is_wr) begin
                            shreg <= sh_next;
                            st    <= ST_LOAD;
                        end else begin
                            st <= ST_RDATA;
                        end
                    end
                    ST_RDATA: if (is_wr) begin
                        st <= ST_IDLE;
                        if (bitcnt != 3'd0) wel <= 1'b0;
                    end else begin
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) addr <= addr + 1'b1;
                    end
                    ST_LOAD: if (is_wr) begin
                        shreg  <= sh_next;
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) begin
                            if (!busy) pvalid[pptr] <= 1'b1;
                            pptr <= pptr + 1'b1;
                        end
                    end else if (bitcnt == 3'd0) begin
                        st <= ST_LCLOSE;
                    end else begin
                        st  <= ST_IDLE;
                        wel <= 1'b0;
                    end
                    ST_LCLOSE: if (ev == EV_W1) begin
                        st <= ST_LARM;
                    end else begin
                        st  <= ST_IDLE;
                        wel <= 1'b0;
                    end
                    ST_LARM: begin
                        st <= ST_IDLE;
                        if (is_wr) wel <= 1'b0;
                    end
                    default: st <= ST_IDLE;
                endcase
            end

            if (start_nv) begin
                busy  <= 1'b1;
                pcnt  <= '0;
                ppage <= lpage;
            end else if (busy) begin
                pcnt <= pcnt + 1'b1;
                if (pcnt == LAST_CNT) begin
                    busy   <= 1'b0;
                    wel    <= 1'b0;
                    pvalid <= '0;
                end
            end

            if (!wp_ok) wel <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (pbuf_we) pbuf[pptr] <= sh_next;
    end

    // one page-buffer slot is offered to the array per clock
    assign pidx      = pcnt[PW-1:0];
    assign arr_we    = busy && (pcnt < PAGE_CNT) && pvalid[pidx];
    assign arr_waddr = {ppage, pidx};
    assign arr_wdata = pbuf[pidx];
    assign rd_addr   = addr;

    assign data_bit = rd_byte[3'd7 - bitcnt];

    always_comb begin
        if (busy)                                   out_bit = 1'b0;
        else if (st == ST_ADONE || st == ST_RDATA)  out_bit = data_bit;
        else                                        out_bit = 1'b1;
    end
endmodule

// File: rtl/sbm_engine.sv
module sbm_engine
    import sbm_pkg::*;
#(
    parameter int AW          = 11,
    parameter int PAGE_BYTES  = 32,
    parameter int PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_ce_n,
    input  logic bus_oe_n,
    input  logic bus_we_n,
    input  logic bus_din,
    input  logic wp_n,
    output logic bus_dout,
    output logic bus_drive
);
    strobe_t       raw_s, syn_s;
    bus_ev_e       ev;
    logic          rd_active, out_bit, eng_busy, eng_wel, arr_we;
    logic [AW-1:0] rd_addr, arr_waddr;
    logic [7:0]    arr_wdata, rd_byte;

    assign raw_s = '{ce_n: bus_ce_n, oe_n: bus_oe_n, we_n: bus_we_n,
                     din: bus_din, wp_n: wp_n};

    sbm_sync #(
        .W       ($bits(strobe_t)),
        .RST_VAL (STROBE_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_s),
        .q   (syn_s)
    );

    sbm_bus_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .strb      (syn_s),
        .ev        (ev),
        .rd_active (rd_active)
    );

    sbm_ctrl #(
        .AW          (AW),
        .PAGE_BYTES  (PAGE_BYTES),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .wp_ok     (syn_s.wp_n),
        .rd_byte   (rd_byte),
        .rd_addr   (rd_addr),
        .arr_we    (arr_we),
        .arr_waddr (arr_waddr),
        .arr_wdata (arr_wdata),
        .out_bit   (out_bit),
        .busy      (eng_busy),
        .wel       (eng_wel)
    );

    sbm_array #(
        .AW (AW),
        .DW (8)
    ) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (arr_wdata),
        .raddr (rd_addr),
        .rdata (rd_byte)
    );

    assign bus_drive = rd_active;
    assign bus_dout  = rd_active & out_bit;
endmodule

// File: rtl/sbm_engine_chk.sv
module sbm_engine_chk (
    input logic clk,
    input logic rst,
    input logic bus_ce_n,
    input logic bus_oe_n,
    input logic bus_we_n,
    input logic wp_n,
    input logic bus_drive,
    input logic bus_dout,
    input logic busy,
    input logic wel,
    input logic arr_we
);
    // R2: the line is driven only for a read cycle seen two clocks earlier
    assert_drive_rd_R2: assert property (@(posedge clk) disable iff (rst)
        bus_drive |-> $past(!bus_ce_n && !bus_oe_n && bus_we_n, 2));

    // R2: nothing is driven outside a read cycle
    assert_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_drive |-> !bus_dout);

    // R8: programming starts only with write permission
    assert_start_wel_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wel));

    // R10: completion leaves write permission clear
    assert_done_clear_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel);

    // R10: write-protect low keeps write permission clear
    assert_wp_hold_R10: assert property (@(posedge clk) disable iff (rst)
        $past(!wp_n, 3) |-> !wel);

    // R7: the array is written only while programming runs
    assert_arr_busy_R7: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy);
endmodule

bind sbm_engine sbm_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_ce_n  (bus_ce_n),
    .bus_oe_n  (bus_oe_n),
    .bus_we_n  (bus_we_n),
    .wp_n      (wp_n),
    .bus_drive (bus_drive),
    .bus_dout  (bus_dout),
    .busy      (eng_busy),
    .wel       (eng_wel),
    .arr_we    (arr_we)
);

// File: tb/tb_sbm_engine.sv
module tb_sbm_engine;
    localparam int PROG = 400;

    logic clk = 1'b0;
    logic rst, ce_n, oe_n, we_n, din, wp_n;
    logic bus_dout, bus_drive;
    logic last_drv;
    logic [7:0] pg [64];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    sbm_engine #(.PROG_CYCLES(PROG)) dut (
        .clk (clk), .rst (rst), .bus_ce_n (ce_n), .bus_oe_n (oe_n),
        .bus_we_n (we_n), .bus_din (din), .wp_n (wp_n),
        .bus_dout (bus_dout), .bus_drive (bus_drive)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic b);
        @(negedge clk);
        din = b; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        repeat (6) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic bus_read(output logic b);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        repeat (6) @(negedge clk);
        b = bus_dout; last_drv = bus_drive;
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic rst_seq();
        logic b;
        bus_read(b); bus_write(1'b0); bus_read(b);
    endtask

    task automatic nv_start();
        logic b;
        bus_read(b); bus_write(1'b1); bus_read(b);
    endtask

    task automatic send_addr(input logic [15:0] a);
        for (int i = 15; i >= 0; i--) bus_write(a[i]);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) bus_write(v[i]);
    endtask

    task automatic read_byte(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bus_read(b);
            v[i] = b;
        end
    endtask

    task automatic wait_done(output int polls);
        logic b;
        polls = 0;
        do begin
            bus_read(b);
            polls++;
        end while (b !== 1'b1 && polls < 200);
    endtask

    task automatic program_bytes(input logic [15:0] a, input int n);
        int polls;
        rst_seq();
        send_addr(a);
        for (int k = 0; k < n; k++) send_byte(pg[k]);
        nv_start();
        wait_done(polls);
    endtask

    task automatic t_reset_state();
        logic b;
        chk("R2", "drive idle", bus_drive, 1'b0);
        chk("R2", "dout idle", bus_dout, 1'b0);
        bus_read(b);
        chk("R2", "drive in read", last_drv, 1'b1);
        chk("R9", "ready after reset", b, 1'b1);
    endtask

    task automatic t_post_reset();
        logic b;
        rst_seq();
        bus_read(b); chk("R3", "read 1 after reset", b, 1'b1);
        bus_read(b); chk("R3", "read 2 after reset", b, 1'b1);
    endtask

    task automatic t_basic_write();
        logic b;
        logic [7:0] v;
        int polls;
        logic [7:0] exp [5] = '{8'hFF, 8'hA5, 8'h3C, 8'h0F, 8'hFF};
        rst_seq();
        send_addr(16'h0045);
        send_byte(8'hA5); send_byte(8'h3C); send_byte(8'h0F);
        nv_start();
        wait_done(polls);
        chk("R9", "busy seen on first poll", (polls > 1), 1'b1);
        chk("R12", "programming length in polls", (polls >= 30 && polls <= 38), 1'b1);
        rst_seq();
        send_addr(16'h0044);
        for (int k = 0; k < 5; k++) begin
            read_byte(v);
            chk("R1 R4 R5 R7", $sformatf("byte at %0h", 16'h44 + k), v, exp[k]);
        end
        bus_write(1'b1);
        bus_read(b);
        chk("R6", "read ended at byte boundary", b, 1'b1);
    endtask

    task automatic t_mid_read();
        logic b;
        logic [3:0] got;
        rst_seq();
        send_addr(16'h0045);
        for (int i = 3; i >= 0; i--) begin
            bus_read(b);
            got[i] = b;
        end
        chk("R5", "first nibble", got, 4'hA);
        bus_write(1'b1);
        for (int i = 3; i >= 0; i--) begin
            bus_read(b);
            got[i] = b;
        end
        chk("R6", "reads after mid-byte write", got, 4'hF);
    endtask

    task automatic t_rollover();
        logic [7:0] v;
        pg[0] = 8'h5A;
        program_bytes(16'h07FF, 1);
        rst_seq();
        send_addr(16'h07FF);
        read_byte(v); chk("R5", "byte at 7FF", v, 8'h5A);
        read_byte(v); chk("R5", "rolled to 000", v, 8'hFF);
    endtask

    task automatic t_page_wrap();
        logic [7:0] v;
        logic [7:0] e;
        for (int k = 0; k < 33; k++) pg[k] = 8'(8'h10 + k);
        program_bytes(16'h011E, 33);
        rst_seq();
        send_addr(16'h0100);
        for (int o = 0; o < 32; o++) begin
            read_byte(v);
            if (o == 30)      e = 8'h30;
            else if (o == 31) e = 8'h11;
            else              e = 8'(8'h12 + o);
            chk("R7", $sformatf("wrapped page offset %0d", o), v, e);
        end
        read_byte(v);
        chk("R7", "next page untouched", v, 8'hFF);
    endtask

    task automatic t_protect();
        logic b;
        logic [7:0] v;
        int polls;
        wp_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_seq();
        send_addr(16'h0200);
        send_byte(8'h77);
        nv_start();
        bus_read(b);
        chk("R10", "no start with protect low", b, 1'b1);
        wp_n = 1'b1;
        repeat (4) @(negedge clk);
        rst_seq();
        send_addr(16'h0201);
        send_byte(8'h96);
        nv_start();
        wp_n = 1'b0;
        bus_read(b);
        chk("R10", "protect low keeps write running", b, 1'b0);
        wait_done(polls);
        wp_n = 1'b1;
        repeat (4) @(negedge clk);
        rst_seq();
        send_addr(16'h0200);
        read_byte(v); chk("R10", "blocked byte", v, 8'hFF);
        read_byte(v); chk("R10", "byte written under late protect", v, 8'h96);
    endtask

    task automatic t_reset_busy();
        logic b;
        logic [7:0] v;
        int polls;
        rst_seq();
        send_addr(16'h0202);
        send_byte(8'hC3);
        nv_start();
        rst_seq();
        bus_read(b);
        chk("R9", "busy after reset in write", b, 1'b0);
        wait_done(polls);
        chk("R9", "ready after write", (polls < 200), 1'b1);
        rst_seq();
        send_addr(16'h0202);
        read_byte(v);
        chk("R3", "reset did not stop write", v, 8'hC3);
    endtask

    task automatic t_illegal();
        logic b;
        logic [7:0] v;
        rst_seq();
        send_addr(16'h0300);
        send_byte(8'h11);
        bus_read(b); bus_write(1'b1); bus_write(1'b1);
        bus_read(b);
        chk("R11", "no start after read-write-write", b, 1'b1);
        bus_write(1'b1); bus_read(b);
        chk("R11", "idle start pattern ignored", b, 1'b1);
        rst_seq();
        send_addr(16'h0301);
        for (int i = 0; i < 4; i++) bus_write(1'b0);
        nv_start();
        bus_read(b);
        chk("R11", "no start after partial byte", b, 1'b1);
        rst_seq();
        for (int i = 0; i < 8; i++) bus_write(1'b0);
        bus_read(b);
        send_byte(8'h45);
        read_byte(v);
        chk("R11", "read in address aborts", v, 8'hFF);
        rst_seq();
        send_addr(16'h0300);
        read_byte(v); chk("R11", "byte 300 untouched", v, 8'hFF);
        read_byte(v); chk("R11", "byte 301 untouched", v, 8'hFF);
    endtask

    initial begin
        #3_000_000;
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; din = 1'b0; wp_n = 1'b1;
        last_drv = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset_state();
        t_post_reset();
        t_basic_write();
        t_mid_read();
        t_rollover();
        t_page_wrap();
        t_protect();
        t_reset_busy();
        t_illegal();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule